// File: doc/BRIEF.md
# Bulk Endpoint FIFO Pair with Shared DMA Channel

This block buffers bulk endpoint traffic between a full-speed device engine and the system bus. It holds one 32-byte receive FIFO, filled by the device engine and drained over the bus, and one 32-byte transmit FIFO, filled over the bus and drained by the device engine. Both FIFOs refuse a write when full and a read when empty, and they record each refused access in sticky status flags.

A single DMA request line serves both directions. After reset it serves receive and asks for service when the receive FIFO is full. When software requests a transmit transfer, the line switches to transmit and asks for service while the transmit FIFO is empty. It switches back to receive once the endpoint side takes the last transmit byte. A control bit sends the same service condition to an interrupt line instead of the DMA line.

Software uses a small register window. Address 0 is the data port, 1 is control, 2 is status, 3 is the receive count and 4 is the transmit count.

Top module: `usb_ep_fifo_dma`

## Requirements
- R1: Each FIFO holds up to 32 bytes and returns them in arrival order. Reading address 3 gives the receive count and reading address 4 gives the transmit count, each 0 to 32 in bits [5:0].
- R2: After reset every status and control bit reads 0, both counts read 0, and the shared channel serves receive (status bit 4 = 0).
- R3: A bus write to control (address 1) with bit 0 set switches the channel to transmit (status bit 4 = 1). A write with bit 0 clear leaves the direction as it was.
- R4: While in transmit, an endpoint pop that removes the last transmit byte, with no accepted bus write to the data port in the same cycle, returns the channel to receive on the next cycle. A pop that leaves bytes behind keeps it in transmit.
- R5: The service condition is "receive FIFO full" in receive direction and "transmit FIFO empty" in transmit direction. The request follows it combinationally and drops in the same cycle the count changes.
- R6: Control bit 1 selects the interrupt line (1) or the DMA line (0) for the service request. The two lines are never high together.
- R7: An endpoint push to a full receive FIFO and a bus data write to a full transmit FIFO are ignored, even if a pop happens in the same cycle. The count and the contents stay unchanged.
- R8: A bus data read of an empty receive FIFO and an endpoint pop of an empty transmit FIFO return 0 and leave the count at 0.
- R9: Status bits 0 to 3 are sticky flags: bit 0 is receive overrun, bit 1 is receive underrun, bit 2 is transmit overrun and bit 3 is transmit underrun. Writing 1 to a flag at address 2 clears it. A new event in the same cycle wins over the clear.
- R10: Control bit 2 flushes the receive FIFO and bit 3 flushes the transmit FIFO; the count reads 0 on the next cycle. A flush discards any push or pop to that FIFO in the same cycle and raises no flag.
- R11: A push and a pop that are both accepted on the same FIFO in one cycle leave the count unchanged and keep byte order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_rx_push | input | 1 | Device engine writes a received byte |
| ep_rx_data | input | 8 | Received byte |
| ep_rx_full | output | 1 | Receive FIFO is full |
| ep_tx_pop | input | 1 | Device engine takes a transmit byte |
| ep_tx_data | output | 8 | Head of transmit FIFO (0 when empty) |
| ep_tx_empty | output | 1 | Transmit FIFO is empty |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| dma_req | output | 1 | DMA service request |
| irq_req | output | 1 | Interrupt service request |

## Verification
A push and a pop can land on the same FIFO in one cycle. The bench provokes this on a partly filled receive FIFO, where both must be taken, and on a full one, where the push must be refused while the pop goes through. A flag-setting event can also fall in the same cycle as a write-one-to-clear of that flag, and a flush can fall in the same cycle as a push. Both are driven on purpose. A reference model in the bench follows the stated priorities at every falling edge and compares each byte read, each count, each flag and the request lines in every cycle.

// File: rtl/usbfd_pkg.sv
package usbfd_pkg;
  localparam int unsigned FIFO_DEPTH = 32;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 3;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXCNT = 3'd4;

  // control bits
  localparam int unsigned C_TXGO  = 0;
  localparam int unsigned C_IRQ   = 1;
  localparam int unsigned C_RXFL  = 2;
  localparam int unsigned C_TXFL  = 3;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } chan_dir_e;

  typedef struct packed {
    logic tx_und;
    logic tx_ovr;
    logic rx_und;
    logic rx_ovr;
  } err_flags_t;
endpackage

// File: rtl/usbfd_fifo.sv
module usbfd_fifo #(
  parameter int unsigned DEPTH = usbfd_pkg::FIFO_DEPTH,
  parameter int unsigned DW    = usbfd_pkg::DATA_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_blk,
  output logic          pop_blk
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr, wr_ptr_nx;
  logic [AW-1:0] rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt_nx;
  logic [DW-1:0] mem [DEPTH];

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign push_ok  = push & ~full & ~flush;
  assign pop_ok   = pop & ~empty & ~flush;
  assign push_blk = push & full & ~flush;
  assign pop_blk  = pop & empty & ~flush;
  assign rdata    = empty ? '0 : mem[rd_ptr];

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (push_ok) wr_ptr_nx = (wr_ptr == LAST_IX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr_nx = (rd_ptr == LAST_IX) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_nx = count + 1'b1;
        2'b01:   cnt_nx = count - 1'b1;
        default: cnt_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/usbfd_chan.sv
module usbfd_chan #(
  parameter int unsigned CW = $clog2(usbfd_pkg::FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_tx,
  input  logic          tx_pop_ok,
  input  logic          tx_push_ok,
  input  logic [CW-1:0] tx_count,
  input  logic          rx_full,
  input  logic          tx_empty,
  input  logic          irq_mode,
  output logic          dir_tx,
  output logic          dma_req,
  output logic          irq_req
);
  import usbfd_pkg::*;

  chan_dir_e dir, dir_nx;
  logic drained, svc;

  assign drained = (dir == DIR_TX) & tx_pop_ok & ~tx_push_ok &
                   (tx_count == CW'(1));

  always_comb begin
    dir_nx = dir;
    if (set_tx)       dir_nx = DIR_TX;
    else if (drained) dir_nx = DIR_RX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir <= DIR_RX;
    else        dir <= dir_nx;
  end

  assign svc     = (dir == DIR_TX) ? tx_empty : rx_full;
  assign dma_req = svc & ~irq_mode;
  assign irq_req = svc & irq_mode;
  assign dir_tx  = (dir == DIR_TX);
endmodule

// File: rtl/usbfd_regs.sv
module usbfd_regs #(
  parameter int unsigned DW = usbfd_pkg::DATA_W,
  parameter int unsigned CW = $clog2(usbfd_pkg::FIFO_DEPTH) + 1,
  parameter int unsigned AW = usbfd_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    ctl_wbits,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] rx_head,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          dir_tx,
  input  logic          rx_push_blk,
  input  logic          rx_pop_blk,
  input  logic          tx_push_blk,
  input  logic          tx_pop_blk,
  output logic          irq_mode,
  output logic          set_tx,
  output logic          rx_flush,
  output logic          tx_flush,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [3:0]    flags
);
  import usbfd_pkg::*;

  localparam int unsigned PADC = DW - CW;

  err_flags_t flg, flg_nx, flg_set;
  logic irq_nx, wr_ctrl, wr_stat;

  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign wr_stat  = bus_wr & (bus_addr == A_STAT);
  assign set_tx   = wr_ctrl & ctl_wbits[C_TXGO];
  assign rx_flush = wr_ctrl & ctl_wbits[C_RXFL];
  assign tx_flush = wr_ctrl & ctl_wbits[C_TXFL];
  assign rx_pop   = bus_rd & (bus_addr == A_DATA);
  assign tx_push  = bus_wr & (bus_addr == A_DATA);

  always_comb begin
    flg_set.rx_ovr = rx_push_blk;
    flg_set.rx_und = rx_pop_blk;
    flg_set.tx_ovr = tx_push_blk;
    flg_set.tx_und = tx_pop_blk;
    flg_nx = flg;
    if (wr_stat) flg_nx = err_flags_t'(flg & ~ctl_wbits);
    flg_nx = err_flags_t'(flg_nx | flg_set);
    irq_nx = wr_ctrl ? ctl_wbits[C_IRQ] : irq_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg      <= '0;
      irq_mode <= 1'b0;
    end else begin
      flg      <= flg_nx;
      irq_mode <= irq_nx;
    end
  end

  assign flags = flg;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rx_head;
      A_CTRL:  bus_rdata = {{(DW-2){1'b0}}, irq_mode, dir_tx};
      A_STAT:  bus_rdata = {{(DW-5){1'b0}}, dir_tx, flg};
      A_RXCNT: bus_rdata = {{PADC{1'b0}}, rx_count};
      A_TXCNT: bus_rdata = {{PADC{1'b0}}, tx_count};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_fifo_dma.sv
module usb_ep_fifo_dma #(
  parameter int unsigned DEPTH = usbfd_pkg::FIFO_DEPTH,
  parameter int unsigned DW    = usbfd_pkg::DATA_W,
  parameter int unsigned AW    = usbfd_pkg::ADDR_W,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ep_rx_push,
  input  logic [DW-1:0] ep_rx_data,
  output logic          ep_rx_full,
  input  logic          ep_tx_pop,
  output logic [DW-1:0] ep_tx_data,
  output logic          ep_tx_empty,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          dma_req,
  output logic          irq_req
);
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic rx_empty, tx_full;
  logic rx_push_ok, rx_pop_ok, rx_push_blk, rx_pop_blk;
  logic tx_push_ok, tx_pop_ok, tx_push_blk, tx_pop_blk;
  logic rx_pop, tx_push, rx_flush, tx_flush, set_tx, irq_mode, dir_tx;
  logic [3:0] flags;
  logic unused_rx;

  assign unused_rx = rx_empty ^ rx_push_ok ^ rx_pop_ok ^ tx_full;

  usbfd_fifo #(.DEPTH(DEPTH), .DW(DW)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n_i),
    .push(ep_rx_push), .wdata(ep_rx_data),
    .pop(rx_pop), .flush(rx_flush),
    .rdata(rx_head), .count(rx_cnt),
    .full(ep_rx_full), .empty(rx_empty),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
    .push_blk(rx_push_blk), .pop_blk(rx_pop_blk)
  );

  usbfd_fifo #(.DEPTH(DEPTH), .DW(DW)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n_i),
    .push(tx_push), .wdata(bus_wdata),
    .pop(ep_tx_pop), .flush(tx_flush),
    .rdata(ep_tx_data), .count(tx_cnt),
    .full(tx_full), .empty(ep_tx_empty),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
    .push_blk(tx_push_blk), .pop_blk(tx_pop_blk)
  );

  usbfd_regs #(.DW(DW), .CW(CW), .AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n_i),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .ctl_wbits(bus_wdata[3:0]), .bus_rdata(bus_rdata),
    .rx_head(rx_head), .rx_count(rx_cnt), .tx_count(tx_cnt),
    .dir_tx(dir_tx),
    .rx_push_blk(rx_push_blk), .rx_pop_blk(rx_pop_blk),
    .tx_push_blk(tx_push_blk), .tx_pop_blk(tx_pop_blk),
    .irq_mode(irq_mode), .set_tx(set_tx),
    .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rx_pop(rx_pop), .tx_push(tx_push), .flags(flags)
  );

  usbfd_chan #(.CW(CW)) chan_i (
    .clk(clk), .rst_n(rst_n_i),
    .set_tx(set_tx), .tx_pop_ok(tx_pop_ok), .tx_push_ok(tx_push_ok),
    .tx_count(tx_cnt), .rx_full(ep_rx_full), .tx_empty(ep_tx_empty),
    .irq_mode(irq_mode), .dir_tx(dir_tx),
    .dma_req(dma_req), .irq_req(irq_req)
  );
endmodule

// File: rtl/usbfd_checker.sv
module usbfd_checker #(
  parameter int unsigned DEPTH = usbfd_pkg::FIFO_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          ep_tx_pop,
  input logic          rx_pop,
  input logic          tx_push,
  input logic          rx_flush,
  input logic          tx_flush,
  input logic          rx_push_blk,
  input logic          set_tx,
  input logic          dir_tx,
  input logic          irq_mode,
  input logic          dma_req,
  input logic          irq_req,
  input logic [3:0]    flags
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= FULLV) && (tx_cnt <= FULLV));

  p_dir_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_tx |=> dir_tx);

  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && tx_cnt > CW'(1)) |=> dir_tx);

  p_dir_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_tx && tx_cnt == CW'(1) && ep_tx_pop && !tx_push && !tx_flush && !set_tx)
      |=> !dir_tx);

  p_rx_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_tx && rx_cnt == FULLV) |-> (dma_req || irq_req));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && irq_req));

  p_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mode |-> !dma_req);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULLV && !rx_pop && !rx_flush) |=> rx_cnt == FULLV);

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '0 && !tx_push) |=> tx_cnt == '0);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_blk |=> flags[0]);

  p_rx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_cnt == '0);

  p_tx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_cnt == '0);
endmodule

bind usb_ep_fifo_dma usbfd_checker chk_i (
  .clk(clk), .rst_n(rst_n_i),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .ep_tx_pop(ep_tx_pop), .rx_pop(rx_pop), .tx_push(tx_push),
  .rx_flush(rx_flush), .tx_flush(tx_flush),
  .rx_push_blk(rx_push_blk), .set_tx(set_tx), .dir_tx(dir_tx),
  .irq_mode(irq_mode), .dma_req(dma_req), .irq_req(irq_req),
  .flags(flags)
);

// File: tb/usb_ep_fifo_dma_tb.sv
module usb_ep_fifo_dma_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_rx_push = 1'b0, ep_tx_pop = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] ep_rx_data = '0, bus_wdata = '0;
  logic [2:0] bus_addr = '0;
  logic [7:0] ep_tx_data, bus_rdata;
  logic ep_rx_full, ep_tx_empty, dma_req, irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usb_ep_fifo_dma dut_i (
    .clk(clk), .rst_n(rst_n),
    .ep_rx_push(ep_rx_push), .ep_rx_data(ep_rx_data), .ep_rx_full(ep_rx_full),
    .ep_tx_pop(ep_tx_pop), .ep_tx_data(ep_tx_data), .ep_tx_empty(ep_tx_empty),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_req(dma_req), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- scoreboard model and monitor ----------------
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [3:0] mflags;
  logic mdir, mirq;

  always @(negedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      mflags = '0; mdir = 1'b0; mirq = 1'b0;
    end else begin
      automatic bit wctl  = bus_wr && bus_addr == 3'd1;
      automatic bit rx_fl = wctl && bus_wdata[2];
      automatic bit tx_fl = wctl && bus_wdata[3];
      automatic bit setg  = wctl && bus_wdata[0];
      automatic int rs = rxq.size();
      automatic int ts = txq.size();
      automatic bit rx_rd  = bus_rd && bus_addr == 3'd0;
      automatic bit tx_wr  = bus_wr && bus_addr == 3'd0;
      automatic bit rx_pok = rx_rd && !rx_fl && rs > 0;
      automatic bit rx_uok = ep_rx_push && !rx_fl && rs < 32;
      automatic bit tx_pok = ep_tx_pop && !tx_fl && ts > 0;
      automatic bit tx_uok = tx_wr && !tx_fl && ts < 32;
      automatic bit svc = mdir ? (ts == 0) : (rs == 32);
      chk("R5 dma_req", int'(dma_req), int'(svc && !mirq));
      chk("R6 irq_req", int'(irq_req), int'(svc && mirq));
      if (bus_rd) begin
        case (bus_addr)
          3'd0: chk("R1/R8 rx data", bus_rdata, rs > 0 ? rxq[0] : 0);
          3'd1: chk("R6 ctrl", bus_rdata, {mirq, mdir});
          3'd2: chk("R9/R4 stat", bus_rdata, {mdir, mflags});
          3'd3: chk("R1 rx count", bus_rdata, rs);
          3'd4: chk("R1 tx count", bus_rdata, ts);
          default: chk("R1 unused addr", bus_rdata, 0);
        endcase
      end
      if (ep_tx_pop) chk("R1/R8 tx data", ep_tx_data, ts > 0 ? txq[0] : 0);
      // state updates, stated priorities
      if (bus_wr && bus_addr == 3'd2) mflags = mflags & ~bus_wdata[3:0];
      if (ep_rx_push && !rx_fl && rs == 32) mflags[0] = 1'b1;
      if (rx_rd && !rx_fl && rs == 0)       mflags[1] = 1'b1;
      if (tx_wr && !tx_fl && ts == 32)      mflags[2] = 1'b1;
      if (ep_tx_pop && !tx_fl && ts == 0)   mflags[3] = 1'b1;
      if (setg) mdir = 1'b1;
      else if (mdir && tx_pok && !tx_uok && ts == 1) mdir = 1'b0;
      if (wctl) mirq = bus_wdata[1];
      if (rx_fl) rxq.delete();
      else begin
        if (rx_pok) void'(rxq.pop_front());
        if (rx_uok) rxq.push_back(ep_rx_data);
      end
      if (tx_fl) txq.delete();
      else begin
        if (tx_pok) void'(txq.pop_front());
        if (tx_uok) txq.push_back(bus_wdata);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic step(input bit p, input logic [7:0] pd, input bit tp,
                      input bit w, input bit r, input logic [2:0] a,
                      input logic [7:0] wd);
    @(posedge clk); #1;
    ep_rx_push = p; ep_rx_data = pd; ep_tx_pop = tp;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = wd;
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 3'd0, 8'h00);
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    step(0, 8'h00, 0, 0, 1, a, 8'h00);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    step(0, 8'h00, 0, 1, 0, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) idle();

    // R2 reset state
    rd_reg(3'd2, v); chk("R2 stat after reset", v, 0);
    rd_reg(3'd1, v); chk("R2 ctrl after reset", v, 0);
    rd_reg(3'd3, v); chk("R2 rx count after reset", v, 0);

    // fill receive FIFO
    for (int i = 0; i < 32; i++) step(1, 8'(i * 7 + 3), 0, 0, 0, 3'd0, 0);
    idle(); @(negedge clk);
    chk("R5 dma_req on rx full", int'(dma_req), 1);
    rd_reg(3'd3, v); chk("R1 rx count full", v, 32);

    // R7 overrun
    step(1, 8'hEE, 0, 0, 0, 3'd0, 0);
    rd_reg(3'd3, v); chk("R7 rx count after blocked push", v, 32);
    rd_reg(3'd2, v); chk("R9 rx overrun flag", v, 8'h01);
    wr_reg(3'd2, 8'h01);
    rd_reg(3'd2, v); chk("R9 w1c clears", v, 0);

    // R11/R7 push+pop on full: push refused, pop taken
    step(1, 8'hAA, 0, 0, 1, 3'd0, 0);
    rd_reg(3'd3, v); chk("R11 full push+pop count", v, 31);
    rd_reg(3'd2, v); chk("R7 blocked push with pop flags", v, 8'h01);
    wr_reg(3'd2, 8'h0F);

    // R11 push+pop on partial
    step(1, 8'h5A, 0, 0, 1, 3'd0, 0);
    rd_reg(3'd3, v); chk("R11 partial push+pop count", v, 31);

    // drain and underrun
    for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 1, 3'd0, 0);
    rd_reg(3'd0, v); chk("R8 empty read returns 0", v, 0);
    rd_reg(3'd2, v); chk("R9 rx underrun flag", v, 8'h02);
    rd_reg(3'd3, v); chk("R8 count stays 0", v, 0);
    wr_reg(3'd2, 8'h0F);

    // R6 interrupt routing
    wr_reg(3'd1, 8'h02);
    for (int i = 0; i < 32; i++) step(1, 8'(255 - i), 0, 0, 0, 3'd0, 0);
    idle(); @(negedge clk);
    chk("R6 irq high", int'(irq_req), 1);
    chk("R6 dma low", int'(dma_req), 0);
    // R9 event and clear in same cycle: set wins
    step(1, 8'h11, 0, 1, 0, 3'd2, 8'h01);
    rd_reg(3'd2, v); chk("R9 set beats clear", v, 8'h01);
    wr_reg(3'd2, 8'h0F);
    // R10 flush with concurrent push
    step(1, 8'h22, 0, 1, 0, 3'd1, 8'h06);
    rd_reg(3'd3, v); chk("R10 rx flush count", v, 0);
    rd_reg(3'd2, v); chk("R10 flush raises no flag", v, 0);
    wr_reg(3'd1, 8'h00);

    // R3 / R4 transmit direction
    wr_reg(3'd1, 8'h01);
    rd_reg(3'd2, v); chk("R3 dir tx", v, 8'h10);
    @(negedge clk); chk("R5 tx empty request", int'(dma_req), 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 3'd0, 8'(8'h40 + i));
    idle(); @(negedge clk);
    chk("R5 request drops with data", int'(dma_req), 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 3'd0, 0);
    rd_reg(3'd2, v); chk("R4 still tx with 1 byte", v, 8'h10);
    // last pop with concurrent bus write: stays tx
    step(0, 0, 1, 1, 0, 3'd0, 8'h77);
    rd_reg(3'd2, v); chk("R4 refill keeps tx", v, 8'h10);
    step(0, 0, 1, 0, 0, 3'd0, 0);
    rd_reg(3'd2, v); chk("R4 back to rx", v, 8'h00);
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd2, v); chk("R3 write 0 keeps rx", v, 8'h00);
    step(0, 0, 1, 0, 0, 3'd0, 0);
    rd_reg(3'd2, v); chk("R8 tx underrun flag", v, 8'h08);
    wr_reg(3'd2, 8'h0F);

    // R7 tx overrun, R10 tx flush
    wr_reg(3'd1, 8'h01);
    for (int i = 0; i < 33; i++) step(0, 0, 0, 1, 0, 3'd0, 8'(i));
    rd_reg(3'd4, v); chk("R7 tx count capped", v, 32);
    rd_reg(3'd2, v); chk("R7 tx overrun flag", v, 8'h14);
    wr_reg(3'd1, 8'h09);
    rd_reg(3'd4, v); chk("R10 tx flush count", v, 0);
    rd_reg(3'd2, v); chk("R10 dir kept after flush", v, 8'h14);
    repeat (3) idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule